// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Control Gating

This block compares a reference clock with a divided feedback clock and produces source (UP) and sink (DOWN) enables for an external charge pump. It samples both clocks in a fast system clock domain and turns each rising edge into a pulse request. A pair of flags records which edge came first, and both flags clear together once both are set. A control stage then shapes the pulses before they leave the block. It can swap the two directions for oscillators whose frequency falls as the tuning voltage rises. It can hold the detector in reset, force a constant source or sink drive, or raise a mid-supply bias enable.

Two comparator inputs report when the pump output is close to the upper or the lower rail. When the matching clamp is enabled, the synchronized comparator result sets a status flag and blocks the drive direction that would push the output further toward that rail. A 4-bit current-magnitude code is registered for the analog pump. A validity flag accompanies it and marks the codes that the pump cannot use.

For normal locking, the hold, force and mid-bias controls all stay at 0. Hold combined with a force bit pre-charges the loop filter to a known level before lock is attempted.

Top module: `cpg_pfd_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the detector state, the synchronizers and the current code register clear. After that edge, `src_en`, `snk_en`, `flag_hi`, `flag_lo` and `icode_q` read 0 and `icode_ok` reads 1. `mid_en` follows `mid_bias`.
- R2: A 0-to-1 change of `ref_clk_in` between two samples sets the UP flag at the second sample's clock edge. A 0-to-1 change of `fb_clk_in` sets the DOWN flag in the same way. Without inversion, force or clamp, `src_en` equals UP and `snk_en` equals DOWN.
- R3: With `wide_pulse` = 0, a cycle in which UP and DOWN are both 1 is followed by a cycle in which both are 0. An edge that arrives during that clearing cycle is dropped.
- R4: With `wide_pulse` = 1, UP and DOWN stay set together for WIDE_EXTRA+1 cycles (4 by default) and then clear.
- R5: With `inv_phase` = 1, `src_en` carries DOWN and `snk_en` carries UP.
- R6: While `pfd_hold` = 1, both detector flags clear at every edge and stay 0, so no pulses come from phase comparison.
- R7: If `force_src` = 1 and `force_snk` = 0, then `src_en` = 1 and `snk_en` = 0. If `force_snk` = 1 and `force_src` = 0, the roles reverse. If both are 1, both outputs are 0. Any force bit overrides the detector and inversion, and it also works while `pfd_hold` = 1.
- R8: `flag_hi` equals `clamp_hi_en` AND the value that `rail_hi_cmp` had two edges earlier. While `flag_hi` = 1, `src_en` = 0.
- R9: `flag_lo` equals `clamp_lo_en` AND the value that `rail_lo_cmp` had two edges earlier. While `flag_lo` = 1, `snk_en` = 0.
- R10: `mid_en` follows `mid_bias` combinationally and has no effect on the other outputs.
- R11: `icode_q` takes `icode` at each clock edge. `icode_ok` = 1 for codes 0 to 11 and 0 for codes 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Reference clock, sampled |
| fb_clk_in | input | 1 | Divided feedback clock, sampled |
| inv_phase | input | 1 | Swap source and sink roles |
| pfd_hold | input | 1 | Hold the detector in reset |
| force_src | input | 1 | Force constant source drive |
| force_snk | input | 1 | Force constant sink drive |
| mid_bias | input | 1 | Request mid-supply bias |
| wide_pulse | input | 1 | Stretch the overlap before clear |
| clamp_hi_en | input | 1 | Enable upper-rail clamp |
| clamp_lo_en | input | 1 | Enable lower-rail clamp |
| icode | input | 4 | Pump current magnitude code |
| rail_hi_cmp | input | 1 | Comparator: output near upper rail |
| rail_lo_cmp | input | 1 | Comparator: output near lower rail |
| src_en | output | 1 | Gated source (UP) enable |
| snk_en | output | 1 | Gated sink (DOWN) enable |
| mid_en | output | 1 | Mid-supply bias enable |
| icode_q | output | 4 | Registered current code |
| icode_ok | output | 1 | Registered code is usable |
| flag_hi | output | 1 | Upper-rail clamp active |
| flag_lo | output | 1 | Lower-rail clamp active |

## Verification
The rail clamp and the forced drive act on the same output in the same cycle. Forcing a direction while the matching comparator toggles must still block that direction once the synchronized flag rises. The bench provokes this by holding `force_src` or `force_snk` during comparator bursts, both with the clamp enabled and with it disabled. The inverted detector is also run into an active clamp. A behavioural model compares every output on every cycle, so the clamp must win at the exact cycle the flag rises. A second collision, a new reference edge landing in the clearing cycle, is provoked by in-phase clocks with and without the wide pulse.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    localparam int CODE_W    = 4;
    localparam int CODE_LAST = 11;

    typedef struct packed {
        logic inv;
        logic hold;
        logic fsrc;
        logic fsnk;
        logic mid;
        logic wide;
        logic chi_en;
        logic clo_en;
    } cp_ctl_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pulse_t;

    function automatic logic code_usable(input logic [CODE_W-1:0] c);
        return (int'(c) <= CODE_LAST);
    endfunction

endpackage

// File: rtl/cpg_pfd_core.sv
module cpg_pfd_core
    import cpg_pkg::*;
#(
    parameter int WIDE_EXTRA = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ref_in,
    input  logic   fb_in,
    input  logic   hold,
    input  logic   wide,
    output pulse_t pls
);
    localparam int CNT_W = (WIDE_EXTRA < 1) ? 1 : $clog2(WIDE_EXTRA + 1);

    logic             ref_d, fb_d;
    logic             up_q, dn_q;
    logic [CNT_W-1:0] cnt_q;
    logic             both, release_c;

    always_comb begin
        both      = up_q & dn_q;
        release_c = both && (!wide || cnt_q == CNT_W'(WIDE_EXTRA));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d <= 1'b0;
            fb_d  <= 1'b0;
            up_q  <= 1'b0;
            dn_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            ref_d <= ref_in;
            fb_d  <= fb_in;
            if (hold || release_c) begin
                up_q  <= 1'b0;
                dn_q  <= 1'b0;
                cnt_q <= '0;
            end else begin
                up_q <= up_q | (ref_in & ~ref_d);
                dn_q <= dn_q | (fb_in & ~fb_d);
                if (both) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pls = '{up: up_q, dn: dn_q};

    // hold leaves no pulse behind
    assert_hold_clears_R6: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!up_q && !dn_q));

    // narrow mode clears the overlap after one cycle
    assert_narrow_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (up_q && dn_q && !wide) |=> (!up_q && !dn_q));

endmodule

// File: rtl/cpg_rail_sync.sv
module cpg_rail_sync #(
    parameter int STAGES = 2,
    parameter int N      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-2:0], d[b]};
        end
        assign q[b] = sh[STAGES-1];
    end
endmodule

// File: rtl/cpg_gate.sv
module cpg_gate
    import cpg_pkg::*;
(
    input  pulse_t  pls,
    input  cp_ctl_t ctl,
    input  logic    hi_s,
    input  logic    lo_s,
    output logic    src_en,
    output logic    snk_en,
    output logic    flag_hi,
    output logic    flag_lo,
    output logic    mid_en
);
    logic src_raw, snk_raw;

    always_comb begin
        if (ctl.fsrc || ctl.fsnk) begin
            src_raw = ctl.fsrc & ~ctl.fsnk;
            snk_raw = ctl.fsnk & ~ctl.fsrc;
        end else if (ctl.inv) begin
            src_raw = pls.dn;
            snk_raw = pls.up;
        end else begin
            src_raw = pls.up;
            snk_raw = pls.dn;
        end
        flag_hi = ctl.chi_en & hi_s;
        flag_lo = ctl.clo_en & lo_s;
        src_en  = src_raw & ~flag_hi;
        snk_en  = snk_raw & ~flag_lo;
        mid_en  = ctl.mid;
    end
endmodule

// File: rtl/cpg_pfd_ctrl.sv
module cpg_pfd_ctrl
    import cpg_pkg::*;
#(
    parameter int WIDE_EXTRA  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk_in,
    input  logic              fb_clk_in,
    input  logic              inv_phase,
    input  logic              pfd_hold,
    input  logic              force_src,
    input  logic              force_snk,
    input  logic              mid_bias,
    input  logic              wide_pulse,
    input  logic              clamp_hi_en,
    input  logic              clamp_lo_en,
    input  logic [CODE_W-1:0] icode,
    input  logic              rail_hi_cmp,
    input  logic              rail_lo_cmp,
    output logic              src_en,
    output logic              snk_en,
    output logic              mid_en,
    output logic [CODE_W-1:0] icode_q,
    output logic              icode_ok,
    output logic              flag_hi,
    output logic              flag_lo
);
    cp_ctl_t    ctl;
    pulse_t     pls;
    logic [1:0] rail_s;

    assign ctl = '{inv: inv_phase, hold: pfd_hold, fsrc: force_src,
                   fsnk: force_snk, mid: mid_bias, wide: wide_pulse,
                   chi_en: clamp_hi_en, clo_en: clamp_lo_en};

    cpg_pfd_core #(.WIDE_EXTRA(WIDE_EXTRA)) i_core (
        .clk(clk), .rst(rst), .ref_in(ref_clk_in), .fb_in(fb_clk_in),
        .hold(pfd_hold), .wide(wide_pulse), .pls(pls)
    );

    cpg_rail_sync #(.STAGES(SYNC_STAGES), .N(2)) i_sync (
        .clk(clk), .rst(rst), .d({rail_hi_cmp, rail_lo_cmp}), .q(rail_s)
    );

    cpg_gate i_gate (
        .pls(pls), .ctl(ctl), .hi_s(rail_s[1]), .lo_s(rail_s[0]),
        .src_en(src_en), .snk_en(snk_en), .flag_hi(flag_hi),
        .flag_lo(flag_lo), .mid_en(mid_en)
    );

    always_ff @(posedge clk) begin
        if (rst) icode_q <= '0;
        else     icode_q <= icode;
    end

    assign icode_ok = code_usable(icode_q);

    assert_hi_blocks_src_R8: assert property (@(posedge clk) disable iff (rst)
        flag_hi |-> !src_en);

    assert_lo_blocks_snk_R9: assert property (@(posedge clk) disable iff (rst)
        flag_lo |-> !snk_en);

    assert_force_both_off_R7: assert property (@(posedge clk) disable iff (rst)
        (force_src && force_snk) |-> (!src_en && !snk_en));

    assert_code_capture_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> icode_q == $past(icode));

    assert_clamp_off_R9: assert property (@(posedge clk) disable iff (rst)
        !clamp_lo_en |-> !flag_lo);

endmodule

// File: tb/test_cpg_pfd_ctrl.sv
module test_cpg_pfd_ctrl;
    localparam int WX = 3;

    logic clk = 0, rst = 1;
    logic ref_r = 0, fb_r = 0, inv = 0, hold = 0, fsrc = 0, fsnk = 0;
    logic mid = 0, wide = 0, chi = 0, clo = 0, rhi = 0, rlo = 0;
    logic [3:0] code = 0;
    logic src_en, snk_en, mid_en, icode_ok, flag_hi, flag_lo;
    logic [3:0] icode_q;

    int total = 0, bad = 0;
    bit started = 0;

    // behavioural model state
    bit m_refd, m_fbd, m_up, m_dn;
    int m_cnt;
    bit h1, h2, l1, l2;
    int m_code;

    always #10 clk = ~clk;

    cpg_pfd_ctrl #(.WIDE_EXTRA(WX), .SYNC_STAGES(2)) i_cpg_pfd_ctrl (
        .clk(clk), .rst(rst), .ref_clk_in(ref_r), .fb_clk_in(fb_r),
        .inv_phase(inv), .pfd_hold(hold), .force_src(fsrc), .force_snk(fsnk),
        .mid_bias(mid), .wide_pulse(wide), .clamp_hi_en(chi), .clamp_lo_en(clo),
        .icode(code), .rail_hi_cmp(rhi), .rail_lo_cmp(rlo),
        .src_en(src_en), .snk_en(snk_en), .mid_en(mid_en), .icode_q(icode_q),
        .icode_ok(icode_ok), .flag_hi(flag_hi), .flag_lo(flag_lo)
    );

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", what, $time, act, exp);
        end
    endtask

    // compare every cycle, then advance the model with the inputs the next edge sees
    always @(negedge clk) begin
        if (started) begin
            bit fh, fl, s, k;
            fh = chi && h2;
            fl = clo && l2;
            if (fsrc || fsnk) begin s = fsrc && !fsnk; k = fsnk && !fsrc; end
            else if (inv)     begin s = m_dn; k = m_up; end
            else              begin s = m_up; k = m_dn; end
            chk("R8 flag_hi", int'(flag_hi), int'(fh));
            chk("R9 flag_lo", int'(flag_lo), int'(fl));
            chk("src_en R2/R3/R4/R5/R6/R7/R8", int'(src_en), int'(s && !fh));
            chk("snk_en R2/R3/R4/R5/R6/R7/R9", int'(snk_en), int'(k && !fl));
            chk("R10 mid_en", int'(mid_en), int'(mid));
            chk("R11 icode_q", int'(icode_q), m_code);
            chk("R11 icode_ok", int'(icode_ok), int'(m_code < 12));
        end
        if (rst) begin
            m_refd = 0; m_fbd = 0; m_up = 0; m_dn = 0; m_cnt = 0;
            h1 = 0; h2 = 0; l1 = 0; l2 = 0; m_code = 0;
        end else begin
            bit r_up, r_dn, rel;
            r_up = ref_r && !m_refd;
            r_dn = fb_r && !m_fbd;
            rel  = m_up && m_dn && (!wide || m_cnt == WX);
            if (hold || rel) begin m_up = 0; m_dn = 0; m_cnt = 0; end
            else begin
                if (m_up && m_dn) m_cnt++;
                m_up = m_up || r_up;
                m_dn = m_dn || r_dn;
            end
            m_refd = ref_r; m_fbd = fb_r;
            h2 = h1; h1 = rhi; l2 = l1; l1 = rlo;
            m_code = int'(code);
        end
        started = 1;
    end

    // drive both clocks with period per; feedback lags by off cycles
    task automatic run(input int cyc, input int per, input int off);
        for (int c = 0; c < cyc; c++) begin
            @(posedge clk); #1;
            ref_r = (c % per) < per / 2;
            fb_r  = ((c + 4 * per - off) % per) < per / 2;
        end
    endtask

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; mid = 1;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        // R1 explicit reset state
        chk("R1 src_en", int'(src_en), 0);
        chk("R1 snk_en", int'(snk_en), 0);
        chk("R1 flags", int'(flag_hi | flag_lo), 0);
        chk("R1 icode_q", int'(icode_q), 0);
        chk("R1 icode_ok", int'(icode_ok), 1);
        chk("R1 mid_en", int'(mid_en), 1);
        @(posedge clk); #1; rst = 0; mid = 0;
        run(64, 10, 3);              // R2 reference leads
        run(64, 10, 7);              // R2 feedback leads
        run(64, 8, 0);               // R3 in-phase overlap
        run(40, 12, 1);              // R3 edge close to clear
        wide = 1; run(64, 12, 0);    // R4
        run(64, 16, 2);
        wide = 0;
        inv = 1; run(64, 10, 3);     // R5
        inv = 0;
        hold = 1; run(40, 10, 3);    // R6
        hold = 0; run(30, 10, 3);
        fsrc = 1; run(20, 10, 3);    // R7
        fsrc = 0; fsnk = 1; run(20, 10, 3);
        fsrc = 1; run(20, 10, 3);
        fsrc = 0; hold = 1; run(20, 10, 3);
        fsnk = 0; fsrc = 1; run(20, 10, 3);
        hold = 0; fsrc = 0;
        // R8 clamp colliding with forced source and with detector
        fsrc = 1;
        for (int k = 0; k < 12; k++) begin chi = k[2]; rhi = k[0]; run(5, 10, 3); end
        fsrc = 0; chi = 1;
        for (int k = 0; k < 10; k++) begin rhi = k[1]; inv = k[2]; run(7, 10, 3); end
        chi = 0; rhi = 0; inv = 0;
        // R9
        fsnk = 1;
        for (int k = 0; k < 12; k++) begin clo = k[2]; rlo = k[0]; run(5, 10, 3); end
        fsnk = 0; clo = 1;
        for (int k = 0; k < 10; k++) begin rlo = k[1]; rhi = k[0]; run(7, 10, 6); end
        clo = 0; rlo = 0; rhi = 0;
        // R10
        mid = 1; run(20, 10, 3); mid = 0; run(5, 10, 3);
        // R11 full code sweep
        for (int c = 0; c < 16; c++) begin code = 4'(c); run(3, 10, 3); end
        code = 4'd5;
        rst = 1; run(3, 10, 3); rst = 0; run(20, 10, 3);   // R1 mid-run reset
        @(negedge clk); #1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule